// File: doc/BRIEF.md
# Sequential Booth Multiplier (radix-2)

This block multiplies two signed two's-complement operands of N bits each and returns a signed product of 2N bits. It takes one clock cycle per multiplier bit. It uses radix-2 Booth recoding, so signed operands need no conversion to magnitudes beforehand and no negation of the result afterwards.

A single register of 2N+1 bits holds the working state:

- The upper N bits form the accumulator.
- The lower N bits start out holding the multiplier.
- One appended bit sits below the least significant bit.

On each step, the multiplier's current low bit and the appended bit together pick one of three actions on the accumulator: add the multiplicand, subtract it, or leave the accumulator unchanged. The whole register then shifts right by one position, and the shift copies the sign bit.

A caller pulses `start` with both operands present while the block is idle. The caller then waits for the one-cycle `done` pulse and reads `product`. The product stays unchanged until the next accepted start.

Top module: `booth_mult`

## Requirements
- R1: A synchronous active-high `rst` drives `busy` and `done` low and clears `product` to zero, including in the middle of a run.
- R2: A `start` that is sampled while idle raises `busy` from the next cycle. `busy` stays high for exactly N cycles. `done` is high for exactly one cycle, namely the first cycle after `busy` falls. `busy` and `done` are never high together.
- R3: In the `done` cycle, `product` equals the 2N-bit two's-complement product of the operands that were sampled with the accepted start.
- R4: The result is exact when either operand, or both, equal the most negative value -2^(N-1). Examples are (-2^(N-1))² and -2^(N-1) × -1.
- R5: The recoding uses the pair (multiplier low bit, appended bit). Pair 10 subtracts the multiplicand, pair 01 adds it, and pairs 00 and 11 leave the accumulator unchanged. As a result, multipliers made of runs of ones, alternating bits, all ones and a lone sign bit all give exact products.
- R6: A `start` that arrives while `busy` is high is ignored. The operands present with it do not change the result, and the run still lasts N cycles.
- R7: After `done`, `product` holds its value until the next accepted start, whatever the operand inputs do in the meantime.
- R8: A zero in either operand gives a product of zero.
- R9: A `start` given in the same cycle that `done` is high is accepted, so runs can follow back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a multiplication; only acted on while idle |
| multiplicandIn | input | N | Signed multiplicand, sampled with an accepted start |
| multiplierIn | input | N | Signed multiplier, sampled with an accepted start |
| busy | output | 1 | High while the N steps are running |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2N | Signed product, held until the next accepted start |

## Verification
The bench builds the block with N = 8. At that width the most negative value -128, its square and all of its mixed-sign pairings can be driven directly. Random pairs also cover the 8-bit operand space densely enough to hit every recoding pair at every step position. The run length is only 8 cycles, so back-to-back runs, a start that arrives in the middle of a run, and a reset during a run all fit into a short test.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Strobes the control unit sends to the datapath.
  typedef struct packed {
    logic load;   // capture operands, clear accumulator
    logic step;   // one recode + arithmetic shift
  } boothCtrl_t;

  typedef enum logic [1:0] {
    BOOTH_KEEP = 2'd0,
    BOOTH_ADD  = 2'd1,
    BOOTH_SUB  = 2'd2
  } boothAct_t;

  // R5: pair {current multiplier bit, appended bit below it}
  function automatic boothAct_t boothRecode(input logic curBit, input logic prevBit);
    boothAct_t act;
    unique case ({curBit, prevBit})
      2'b10:   act = BOOTH_SUB;  // a run of ones begins
      2'b01:   act = BOOTH_ADD;  // a run of ones has ended
      default: act = BOOTH_KEEP; // 00 or 11: inside a run
    endcase
    return act;
  endfunction

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int N = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output boothCtrl_t strobes,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = (N > 2) ? $clog2(N) : 1;
  localparam int LAST  = N - 1;

  logic             busyQ;
  logic             doneQ;
  logic [CNT_W-1:0] stepCnt;
  logic             lastStep;

  assign lastStep = (stepCnt == CNT_W'(LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      stepCnt <= '0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (start) begin
          busyQ   <= 1'b1;
          stepCnt <= '0;
        end
      end else begin
        stepCnt <= stepCnt + 1'b1;
        if (lastStep) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes.load = start && !busyQ;
    strobes.step = busyQ;
  end

  assign busy = busyQ;
  assign done = doneQ;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R2
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !lastStep) |=> (busy && stepCnt == CNT_W'($past(stepCnt) + 1'b1))); // R6

endmodule

// File: rtl/booth_dpath.sv
module booth_dpath
  import booth_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  boothCtrl_t   strobes,
  input  logic [N-1:0] multiplicandIn,
  input  logic [N-1:0] multiplierIn,
  output logic [2*N-1:0] product
);

  localparam int EXT_W = N + 1;

  logic [N-1:0]     mcandQ;
  logic [N-1:0]     accHiQ;    // accumulator half
  logic [N-1:0]     accLoQ;    // multiplier half
  logic             appendQ;   // bit appended below the LSB
  boothAct_t        act;
  logic [EXT_W-1:0] hiExt;
  logic [EXT_W-1:0] mcandExt;
  logic [EXT_W-1:0] sumExt;

  assign act      = boothRecode(accLoQ[0], appendQ);
  assign hiExt    = {accHiQ[N-1], accHiQ};
  assign mcandExt = {mcandQ[N-1], mcandQ};

  // One extra bit keeps the true sign when subtracting the most negative value.
  always_comb begin
    unique case (act)
      BOOTH_ADD: sumExt = hiExt + mcandExt;
      BOOTH_SUB: sumExt = hiExt - mcandExt;
      default:   sumExt = hiExt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcandQ  <= '0;
      accHiQ  <= '0;
      accLoQ  <= '0;
      appendQ <= 1'b0;
    end else if (strobes.load) begin
      mcandQ  <= multiplicandIn;
      accHiQ  <= '0;
      accLoQ  <= multiplierIn;
      appendQ <= 1'b0;
    end else if (strobes.step) begin
      // arithmetic right shift of {sumExt, accLoQ, appendQ}
      accHiQ  <= sumExt[EXT_W-1:1];
      accLoQ  <= {sumExt[0], accLoQ[N-1:1]};
      appendQ <= accLoQ[0];
    end
  end

  assign product = {accHiQ, accLoQ};

  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!strobes.load && !strobes.step) |=> $stable(product)); // R7
  AST_APPEND_FROM_LSB: assert property (@(posedge clk) disable iff (rst)
    strobes.step |=> (appendQ == $past(accLoQ[0]))); // R5
  AST_LOW_SHIFT: assert property (@(posedge clk) disable iff (rst)
    strobes.step |=> (accLoQ[N-2:0] == $past(accLoQ[N-1:1]))); // R5
  AST_MCAND_KEPT: assert property (@(posedge clk) disable iff (rst)
    strobes.step |=> $stable(mcandQ)); // R6

endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int N = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N-1:0]   multiplicandIn,
  input  logic [N-1:0]   multiplierIn,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);

  boothCtrl_t strobes;

  booth_ctrl #(.N(N)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  booth_dpath #(.N(N)) uDpath (
    .clk            (clk),
    .rst            (rst),
    .strobes        (strobes),
    .multiplicandIn (multiplicandIn),
    .multiplierIn   (multiplierIn),
    .product        (product)
  );

endmodule

// File: tb/sim_booth_mult.sv
module sim_booth_mult;

  localparam int N          = 8;
  localparam int W          = 2 * N;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [N-1:0] mcIn = '0;
  logic [N-1:0] mpIn = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] product;

  int           checks = 0;
  int           fails = 0;
  int           busyRun = 0;
  bit           finished = 1'b0;
  logic [W-1:0] lastExp = '0;
  logic [W-1:0] expQ[$];
  string        tagQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  booth_mult #(.N(N)) u0 (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .multiplicandIn (mcIn),
    .multiplierIn   (mpIn),
    .busy           (busy),
    .done           (done),
    .product        (product)
  );

  task automatic report(input bit ok, input string tag, input logic [W-1:0] act,
                        input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [W-1:0] refMul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic signed [W-1:0] ea;
    logic signed [W-1:0] eb;
    ea = {{N{a[N-1]}}, a};
    eb = {{N{b[N-1]}}, b};
    return ea * eb;
  endfunction

  // Monitor: pop and compare when the design signals completion.
  always @(negedge clk) begin
    if (rst) begin
      busyRun = 0;
    end else begin
      if (busy) busyRun++;
      if (done) begin
        if (expQ.size() == 0) begin
          report(1'b0, "R2 unexpected done", product, '0);
        end else begin
          logic [W-1:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          report(product == e, t, product, e);
          report(busyRun == N, "R2 busy length", W'(busyRun), W'(N));
          lastExp = e;
        end
        busyRun = 0;
      end
    end
  end

  task automatic waitDone();
    int guard = 0;
    while (!done && guard < 4 * N) begin
      @(negedge clk);
      guard++;
    end
    if (!done) report(1'b0, "R2 done never seen", '0, 1);
  endtask

  // Driver: called at a negedge; returns at the negedge where done is high.
  task automatic issue(input logic [N-1:0] a, input logic [N-1:0] b, input string tag);
    start = 1'b1;
    mcIn  = a;
    mpIn  = b;
    expQ.push_back(refMul(a, b));
    tagQ.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    report(busy == 1'b1 && done == 1'b0, "R2 busy after start", {busy, done}, 2'b10);
    waitDone();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      report(1'b0, "watchdog expired", '0, '0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    report(busy == 1'b0, "R1 busy after reset", W'(busy), '0);
    report(done == 1'b0, "R1 done after reset", W'(done), '0);
    report(product == '0, "R1 product after reset", product, '0);
    @(negedge clk);

    // Scaled worked example: 2 * -3 = -6
    issue(8'h02, 8'hFD, "R3 2*-3");
    @(negedge clk);
    // R4 most negative operand
    issue(8'h80, 8'h80, "R4 min*min");
    issue(8'h80, 8'h7F, "R4 min*max");
    issue(8'h7F, 8'h80, "R4 max*min");
    issue(8'h80, 8'hFF, "R4 min*-1");
    issue(8'hFF, 8'h80, "R4 -1*min");
    issue(8'h80, 8'h01, "R4 min*1");
    issue(8'h7F, 8'h7F, "R3 max*max");
    // R5 recoding patterns in the multiplier
    issue(8'h35, 8'hFF, "R5 all ones");
    issue(8'hC3, 8'h55, "R5 alternating 01");
    issue(8'h3B, 8'hAA, "R5 alternating 10");
    issue(8'hE7, 8'h3C, "R5 run of ones");
    issue(8'h59, 8'h80, "R5 lone sign bit");
    issue(8'h9A, 8'h7E, "R5 inner run");
    // R8 zeros
    issue(8'h00, 8'hA7, "R8 zero mcand");
    issue(8'h6D, 8'h00, "R8 zero mplier");
    issue(8'h80, 8'h00, "R8 min*zero");
    // R9 back-to-back (issue returns in the done cycle)
    issue(8'h11, 8'hEE, "R9 back-to-back a");
    issue(8'hF0, 8'h0F, "R9 back-to-back b");
    @(negedge clk);

    // R6 start while busy
    start = 1'b1; mcIn = 8'h23; mpIn = 8'hC5;
    expQ.push_back(refMul(8'h23, 8'hC5));
    tagQ.push_back("R6 start while busy");
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; mcIn = 8'h7F; mpIn = 8'h7F;
    @(negedge clk);
    start = 1'b0; mcIn = 8'h80; mpIn = 8'h55;
    waitDone();

    // R7 hold after done
    @(negedge clk);
    mcIn = 8'h01; mpIn = 8'h02;
    repeat (6) @(negedge clk);
    report(product == refMul(8'h23, 8'hC5), "R7 product held", product, refMul(8'h23, 8'hC5));
    report(product == lastExp, "R7 held matches last", product, lastExp);

    // R1 reset mid-run
    start = 1'b1; mcIn = 8'h45; mpIn = 8'h67;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    report(busy == 1'b0, "R1 busy after mid-run reset", W'(busy), '0);
    report(done == 1'b0, "R1 done after mid-run reset", W'(done), '0);
    report(product == '0, "R1 product after mid-run reset", product, '0);
    repeat (2 * N) @(negedge clk);
    report(done == 1'b0 && busy == 1'b0, "R1 idle stays idle", {busy, done}, '0);

    // R3 random pairs, alternating gaps and back-to-back
    for (int i = 0; i < 200; i++) begin
      logic [N-1:0] a;
      logic [N-1:0] b;
      a = N'($urandom);
      b = N'($urandom);
      issue(a, b, "R3 random");
      if (i % 3 == 0) @(negedge clk);
    end
    @(negedge clk);
    @(negedge clk);
    report(expQ.size() == 0, "R2 all results seen", W'(expQ.size()), '0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule